// File: doc/BRIEF.md
# Buffered Output Compare Timer

This block is a timer built around a free-running up-counter with a programmable wrap value. Two output-compare channels share the counter. Without linking, each channel drives its own pin. At counter wrap the channel sets its pin high. When the counter reaches the channel's compare value, the channel clears the pin low. The result on each pin is a pulse-width-modulated waveform.

A link bit joins both compare registers into one double-buffered channel that drives pin 0. Only one register is in force at any time. At each wrap, control passes to whichever register software wrote last. Software can therefore prepare the next pulse width in the idle register without disturbing the pulse in progress. While the pair is linked, pin 1 is released to a general-purpose value supplied from outside. Writes to channel 1's own control word are dropped during that time. Sticky match and wrap flags, each with its own enable, feed a single interrupt line.

Software uses a single-cycle write port. Address 0 is compare A, address 1 is compare B, address 2 is the wrap value, address 3 is control word A and address 4 is control word B. The counter advances only on cycles where `tick_i` is high.

Top module: `boc_timer`

## Requirements
- R1: On a tick with the counter below the wrap value, the counter adds one. On a tick with the counter at or above the wrap value, the counter goes to 0, and that cycle is an overflow. With `tick_i` low, the counter and both pins hold their values.
- R2: An unlinked channel drives its pin high in the cycle after an overflow. It drives its pin low in the cycle after a tick on which the counter equals its compare value, unless that tick is also an overflow, in which case the overflow wins. With wrap value M and compare C < M, the pin is high for C+1 of every M+1 ticks. With C >= M, the pin stays high.
- R3: Writing 1 to bit 0 (link) of control word A while unlinked makes compare A the register in force.
- R4: In link mode, a write to compare B does not change the pulse in progress. Compare B takes control from the next overflow on.
- R5: In link mode, each overflow hands control to the compare register written most recently. A compare write that lands on the overflow cycle itself counts only from the following overflow.
- R6: A write to the compare register currently in force takes effect in the current period.
- R7: In link mode, `pin1_o` equals `gpio_i`, and writes to control word B are discarded. A channel B interrupt enable written while linked stays off after unlinking.
- R8: A match flag is set by its channel's compare match and stays set until cleared. In link mode, flag A is set by a match of the register in force. Writing 1 to bit 3 of control word A clears flag A. Writing 1 to bit 3 of control word B clears flag B. A set and a clear in the same cycle leave the flag set.
- R9: The overflow flag is set by every overflow and stays set. Writing 1 to bit 4 of control word A clears it.
- R10: `irq_o` is high when any flag is set together with its enable. The enables are bit 1 of control word A for flag A, bit 2 of control word A for the overflow flag, and bit 1 of control word B for flag B.
- R11: After reset the counter, both pins, all flags and `irq_o` are 0, and the block is unlinked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter advance enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 cmp A, 1 cmp B, 2 wrap, 3 ctl A, 4 ctl B) |
| wr_data_i | input | CNT_W | Register write data |
| gpio_i | input | 1 | Value driven on pin 1 while linked |
| pin0_o | output | 1 | Channel A / linked compare output |
| pin1_o | output | 1 | Channel B output or general-purpose value |
| cnt_o | output | CNT_W | Current counter value |
| cmp0_flag_o | output | 1 | Sticky match flag A |
| cmp1_flag_o | output | 1 | Sticky match flag B |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Combined gated interrupt |

## Verification
On every cycle, the assertions check the following: the counter wraps and holds on idle ticks, a pin follows the overflow and match events one cycle later, the register in force is unchanged between overflows and starts as compare A when linking begins, and flags stay set until they are cleared. Other properties show up only over whole periods, and only the bench's scenarios can check them. These are the pulse widths for many wrap and compare pairs, the handover of control to the last-written register, the deferral of a write that lands on the overflow cycle, the immediate effect of rewriting the register in force, and the discarding of control word B while linked.

// File: rtl/boc_pkg.sv
package boc_pkg;
   typedef enum logic [2:0] {
      ADDR_CMP0 = 3'd0,
      ADDR_CMP1 = 3'd1,
      ADDR_MOD  = 3'd2,
      ADDR_CTL0 = 3'd3,
      ADDR_CTL1 = 3'd4
   } reg_addr_e;

   localparam int unsigned ADDR_W   = 3;
   localparam int unsigned N_CH     = 2;
   // control word bit positions
   localparam int unsigned B_LINK   = 0;
   localparam int unsigned B_IE_CMP = 1;
   localparam int unsigned B_IE_OVF = 2;
   localparam int unsigned B_CLR_CM = 3;
   localparam int unsigned B_CLR_OV = 4;
   localparam int unsigned CTL_MINW = 5;
endpackage

// File: rtl/boc_counter.sv
module boc_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] mod_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_top;

   assign at_top = (cnt_q >= mod_i);
   assign ovf_o  = tick_i & at_top;
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      end
   end

   AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && cnt_q >= mod_i) |=> (cnt_q == '0)); // R1
   AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/boc_channel.sv
module boc_channel #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             ovf_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic             match_o,
   output logic             pin_o
);
   logic pin_q;

   assign match_o = tick_i & (cnt_i == cmp_i);
   assign pin_o   = pin_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pin_q <= 1'b0;
      end else if (run_i) begin
         if (ovf_i) begin
            pin_q <= 1'b1;
         end else if (match_o) begin
            pin_q <= 1'b0;
         end
      end
   end

   AST_PIN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && ovf_i) |=> pin_q); // R2
   AST_PIN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && match_o && !ovf_i) |=> !pin_q); // R2
endmodule

// File: rtl/boc_link.sv
module boc_link (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic link_i,
   input  logic link_rise_i,
   input  logic wr_a_i,
   input  logic wr_b_i,
   input  logic ovf_i,
   output logic sel_o
);
   logic sel_q;
   logic last_q;

   assign sel_o = sel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q  <= 1'b0;
         last_q <= 1'b0;
      end else if (link_rise_i) begin
         sel_q  <= 1'b0;
         last_q <= 1'b0;
      end else if (link_i) begin
         if (ovf_i) begin
            sel_q <= last_q;
         end
         if (wr_a_i) begin
            last_q <= 1'b0;
         end else if (wr_b_i) begin
            last_q <= 1'b1;
         end
      end else begin
         sel_q  <= 1'b0;
         last_q <= 1'b0;
      end
   end

   AST_SEL_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_rise_i |=> !sel_q); // R3
   AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (link_i && !ovf_i && !link_rise_i) |=> $stable(sel_q)); // R4
endmodule

// File: rtl/boc_timer.sv
module boc_timer
   import boc_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_addr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             gpio_i,
   output logic             pin0_o,
   output logic             pin1_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             cmp0_flag_o,
   output logic             cmp1_flag_o,
   output logic             ovf_flag_o,
   output logic             irq_o
);
   localparam logic [CNT_W-1:0] RST_VAL = '1;

   if (CNT_W < CTL_MINW || CNT_W > 32) begin : g_bad_width
      $error("boc_timer: CNT_W must lie in 5..32");
   end

   logic [CNT_W-1:0] cmp_q [N_CH];
   logic [CNT_W-1:0] mod_q;
   logic             link_q, ie0_q, ieo_q, ie1_q;
   logic             flag0_q, flag1_q, flago_q;

   logic             wr_c0, wr_c1, wr_mod, wr_ctl0, wr_ctl1;
   logic             link_rise, ovf, sel;
   logic [CNT_W-1:0] ch_cmp [N_CH];
   logic             ch_run [N_CH];
   logic             ch_match [N_CH];
   logic             ch_pin [N_CH];
   logic             clr0, clr1, clro;

   assign wr_c0   = wr_en_i && (wr_addr_i == ADDR_CMP0);
   assign wr_c1   = wr_en_i && (wr_addr_i == ADDR_CMP1);
   assign wr_mod  = wr_en_i && (wr_addr_i == ADDR_MOD);
   assign wr_ctl0 = wr_en_i && (wr_addr_i == ADDR_CTL0);
   assign wr_ctl1 = wr_en_i && (wr_addr_i == ADDR_CTL1) && !link_q;
   assign link_rise = wr_ctl0 && wr_data_i[B_LINK] && !link_q;
   assign clr0 = wr_ctl0 && wr_data_i[B_CLR_CM];
   assign clro = wr_ctl0 && wr_data_i[B_CLR_OV];
   assign clr1 = wr_ctl1 && wr_data_i[B_CLR_CM];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmp_q[0] <= RST_VAL;
         cmp_q[1] <= RST_VAL;
         mod_q    <= RST_VAL;
         link_q   <= 1'b0;
         ie0_q    <= 1'b0;
         ieo_q    <= 1'b0;
         ie1_q    <= 1'b0;
      end else begin
         if (wr_c0)   cmp_q[0] <= wr_data_i;
         if (wr_c1)   cmp_q[1] <= wr_data_i;
         if (wr_mod)  mod_q    <= wr_data_i;
         if (wr_ctl0) begin
            link_q <= wr_data_i[B_LINK];
            ie0_q  <= wr_data_i[B_IE_CMP];
            ieo_q  <= wr_data_i[B_IE_OVF];
         end
         if (wr_ctl1) ie1_q <= wr_data_i[B_IE_CMP];
      end
   end

   boc_counter #(.CNT_W(CNT_W)) u_counter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .mod_i  (mod_q),
      .cnt_o  (cnt_o),
      .ovf_o  (ovf)
   );

   boc_link u_link (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .link_i      (link_q),
      .link_rise_i (link_rise),
      .wr_a_i      (wr_c0),
      .wr_b_i      (wr_c1),
      .ovf_i       (ovf),
      .sel_o       (sel)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      if (i == 0) begin : g_lead
         assign ch_cmp[i] = (link_q && sel) ? cmp_q[1] : cmp_q[0];
         assign ch_run[i] = 1'b1;
      end else begin : g_follow
         assign ch_cmp[i] = cmp_q[i];
         assign ch_run[i] = !link_q;
      end
      boc_channel #(.CNT_W(CNT_W)) u_ch (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .tick_i  (tick_i),
         .run_i   (ch_run[i]),
         .ovf_i   (ovf),
         .cnt_i   (cnt_o),
         .cmp_i   (ch_cmp[i]),
         .match_o (ch_match[i]),
         .pin_o   (ch_pin[i])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag0_q <= 1'b0;
         flag1_q <= 1'b0;
         flago_q <= 1'b0;
      end else begin
         if (ch_match[0])                flag0_q <= 1'b1;
         else if (clr0)                  flag0_q <= 1'b0;
         if (ch_match[1] && !link_q)     flag1_q <= 1'b1;
         else if (clr1)                  flag1_q <= 1'b0;
         if (ovf)                        flago_q <= 1'b1;
         else if (clro)                  flago_q <= 1'b0;
      end
   end

   assign pin0_o      = ch_pin[0];
   assign pin1_o      = link_q ? gpio_i : ch_pin[1];
   assign cmp0_flag_o = flag0_q;
   assign cmp1_flag_o = flag1_q;
   assign ovf_flag_o  = flago_q;
   assign irq_o       = (flag0_q & ie0_q) | (flago_q & ieo_q) | (flag1_q & ie1_q);

   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag0_q && !clr0) |=> flag0_q); // R8
   AST_OVF_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && cnt_o >= mod_q) |=> flago_q); // R9
endmodule

// File: tb/test_boc_timer.sv
`timescale 1ns/1ps
module test_boc_timer;
   localparam int W = 16;
   localparam int NV = 6;
   // mod, cmpA, cmpB, expected high ticks pin0, pin1 per period
   localparam int VEC [NV][5] = '{
      '{15, 3,  9,  4, 10},
      '{15, 0, 15,  1, 16},
      '{15, 14, 20, 15, 16},
      '{7,  5,  2,  6,  3},
      '{3,  1,  0,  2,  1},
      '{3,  3,  2,  4,  3}
   };

   logic clk = 0, rst_n = 0, tick = 1, wr_en = 0, gpio = 0;
   logic [2:0] wr_addr = 0;
   logic [W-1:0] wr_data = 0;
   logic pin0, pin1, f0, f1, fo, irq;
   logic [W-1:0] cnt;
   int n_run = 0, n_fail = 0, cur_mod = 0;

   always #4 clk = ~clk;

   boc_timer #(.CNT_W(W)) i_boc_timer (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .gpio_i(gpio),
      .pin0_o(pin0), .pin1_o(pin1), .cnt_o(cnt), .cmp0_flag_o(f0),
      .cmp1_flag_o(f1), .ovf_flag_o(fo), .irq_o(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1; wr_addr = a[2:0]; wr_data = d[W-1:0];
      @(posedge clk);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic wait_cnt(input int v);
      while (cnt != v[W-1:0]) @(negedge clk);
   endtask

   task automatic period_high(output int h0, output int h1);
      wait_cnt(0);
      h0 = 0; h1 = 0;
      for (int i = 0; i <= cur_mod; i++) begin
         if (pin0) h0++;
         if (pin1) h1++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int h0, h1, c;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(cnt == 0 && !pin0 && !pin1, "R11 pins/counter", {cnt, pin0, pin1}, 0);
      check(!f0 && !f1 && !fo && !irq, "R11 flags", {f0, f1, fo, irq}, 0);
      rst_n = 1;
      @(negedge clk);

      // R2 unlinked pulse widths, table walk
      foreach (VEC[v]) begin
         wr(2, VEC[v][0]); cur_mod = VEC[v][0];
         wr(0, VEC[v][1]);
         wr(1, VEC[v][2]);
         period_high(h0, h1);
         period_high(h0, h1);
         check(h0 == VEC[v][3], "R2 pin0 width", h0, VEC[v][3]);
         check(h1 == VEC[v][4], "R2 pin1 width", h1, VEC[v][4]);
      end

      // R1 wrap at mod
      cur_mod = 15;
      wr(2, 15);
      wait_cnt(15); @(negedge clk);
      check(cnt == 0, "R1 wrap", cnt, 0);
      // R1 tick gating
      tick = 0;
      c = cnt; h0 = pin0;
      repeat (5) @(negedge clk);
      check(cnt == c && pin0 == h0, "R1 hold on idle tick", cnt, c);
      tick = 1;

      // R3 link start: cmp A in force
      wr(0, 3); wr(1, 10);
      wr(3, 1);
      period_high(h0, h1);
      check(h0 == 4, "R3 link starts with cmp A", h0, 4);
      // R4 write B: not in current period
      wr(1, 10);
      wait_cnt(5);
      check(pin0 == 0, "R4 current pulse unchanged", pin0, 0);
      period_high(h0, h1);
      check(h0 == 11, "R4 cmp B after overflow", h0, 11);
      // R5 last written takes over
      wr(0, 6);
      period_high(h0, h1);
      check(h0 == 7, "R5 cmp A retakes", h0, 7);
      // R6 write to register in force is immediate
      wr(0, 12);
      wait_cnt(9);
      check(pin0 == 1, "R6 immediate effect", pin0, 1);
      period_high(h0, h1);
      check(h0 == 13, "R6 new width", h0, 13);
      // R5 write on overflow cycle deferred
      wait_cnt(15);
      wr(1, 2);
      period_high(h0, h1);
      check(h0 == 13, "R5 deferred write not yet", h0, 13);
      period_high(h0, h1);
      check(h0 == 3, "R5 deferred write later", h0, 3);

      // R7 gpio pass-through and ctl B ignored
      gpio = 1; @(negedge clk);
      check(pin1 == 1, "R7 gpio high", pin1, 1);
      gpio = 0; @(negedge clk);
      check(pin1 == 0, "R7 gpio low", pin1, 0);
      wr(4, 2);

      // R8 flag A in link mode
      check(f0 == 1, "R8 flag A set by match in force", f0, 1);
      wait_cnt(0);
      wr(3, 1 + 8 + 16);
      check(f0 == 0, "R8 flag A cleared", f0, 0);
      check(fo == 0, "R9 ovf flag cleared", fo, 0);
      wait_cnt(3);
      check(f0 == 1, "R8 flag A set again", f0, 1);
      // R9 overflow flag
      wait_cnt(15);
      check(fo == 0, "R9 ovf flag before wrap", fo, 0);
      @(negedge clk);
      check(fo == 1, "R9 ovf flag after wrap", fo, 1);

      // unlink, all enables off
      wr(3, 8 + 16);
      wait_cnt(0); @(negedge clk);
      wait_cnt(4);
      check(f1 == 1, "R8 flag B set unlinked", f1, 1);
      check(irq == 0, "R7 ctl B write while linked discarded", irq, 0);
      wait_cnt(0);
      wr(4, 2 + 8);
      check(f1 == 0 && irq == 0, "R10 flag B cleared irq low", {f1, irq}, 0);
      wait_cnt(4);
      check(irq == 1, "R10 irq from flag B", irq, 1);
      wr(4, 8);
      wait_cnt(0); @(negedge clk);
      wr(3, 4);
      check(irq == 1, "R10 irq from ovf flag", irq, 1);
      wr(3, 16);
      check(irq == 0, "R10 irq off without enable", irq, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule